// File: doc/BRIEF.md
# Oversampled Edge Coincidence Counter

This block watches two free-running, clock-like signals that share no clock with the logic around them. It samples both with one fast sample clock and finds the sample cycle in which both of them rise together. The sample clock must run at least twice as fast as the faster of the two watched signals, and a larger ratio gives finer resolution. Each signal is resynchronised first. A rising edge is then found by comparing the current sample of the signal with the sample taken one cycle earlier.

It is used for vernier-style interval measurement. A start pulse arms a counter. The counter advances once for every rising edge of the reference signal (signal A). It freezes at the first qualified coincidence of both edges and raises a done flag. A one-cycle pulse marks every qualified coincidence. A sticky flag records that at least one coincidence has occurred since the last start. Two synchronous qualifier inputs can suppress a coincidence.

Top module: `edge_coincidence_counter`

## Requirements
- R1: Each watched input passes through a two-register synchroniser, then a previous-sample register. A pair of rising edges presented before sample-clock edge k produces `hit_o` high after edge k+2.
- R2: Only a 0-to-1 change between consecutive synchronised samples counts as an edge. Falling edges and steady levels neither advance the counter nor produce a coincidence.
- R3: A coincidence requires a rising edge on both inputs in the same sample cycle, with `qual_a_i` and `qual_b_i` both high at the clock edge where the coincidence is registered.
- R4: `hit_o` is high for exactly one cycle per coincidence. It is never high in two consecutive cycles.
- R5: `hit_seen_o` is set by a coincidence and stays set until the next start or reset.
- R6: A cycle with `start_i` high clears `count_o`, `done_o`, `ovf_o` and `hit_seen_o`, and puts the block in the counting phase.
- R7: In the counting phase, each rising edge of input A that does not coincide increments `count_o` by one. Before the first start, nothing is counted.
- R8: A coincidence in the counting phase sets `done_o` and holds `count_o`. The A edge of that coincidence cycle is not counted. Later edges change neither output until the next start or reset.
- R9: `count_o` saturates at all ones. An A edge that arrives while the count is all ones sets `ovf_o`, which stays set until start or reset.
- R10: A synchronous active-high `rst_i` clears every register, including the synchroniser and previous-sample registers. A watched input held high across reset release is therefore seen as a rising edge.
- R11: If `start_i` is high in the same cycle a coincidence is registered, the start wins. `hit_o` still pulses, but `hit_seen_o` ends clear, `done_o` is low and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear and arm the measurement |
| sig_a_i | input | 1 | Asynchronous reference signal, whose edges are counted |
| sig_b_i | input | 1 | Asynchronous second signal |
| qual_a_i | input | 1 | Coincidence qualifier, must be high |
| qual_b_i | input | 1 | Coincidence qualifier, must be high |
| hit_o | output | 1 | One-cycle qualified coincidence pulse |
| hit_seen_o | output | 1 | Sticky coincidence flag |
| count_o | output | CNT_W | Reference-edge count, frozen at coincidence |
| done_o | output | 1 | Measurement ended by a coincidence |
| ovf_o | output | 1 | Count saturated before a coincidence |

## Verification
Counting an edge of A and ending the measurement can land in the same sample cycle, because every coincidence includes an A edge. The bench drives both inputs high on the same step and confirms that the count does not advance on the cycle where `done_o` rises. It also places a start pulse on exactly the cycle where a coincidence registers, and checks that the restart takes priority. Constrained random toggling, with a share of steps that toggle both inputs together, repeats both collisions many times. Each outcome is compared with a cycle model written in the bench from the requirements.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/ecc_sync.sv
module ecc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecc_rise_det.sv
module ecc_rise_det #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = cur_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise_o[i] = cur_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/ecc_meas.sv
module ecc_meas
    import ecc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             rise_ref_i,
    input  logic             rise_oth_i,
    input  logic             qual_a_i,
    input  logic             qual_b_i,
    output logic             hit_o,
    output logic             hit_seen_o,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             sticky;
        logic             hit;
    } meas_t;

    meas_t st_d, st_q;
    logic  coin;

    always_comb begin
        coin = rise_ref_i & rise_oth_i & qual_a_i & qual_b_i;
        st_d = st_q;
        st_d.hit = coin;
        if (start_i) begin
            st_d.phase  = PH_RUN;
            st_d.cnt    = '0;
            st_d.ovf    = 1'b0;
            st_d.sticky = 1'b0;
        end else begin
            if (coin) st_d.sticky = 1'b1;
            if (st_q.phase == PH_RUN) begin
                if (coin) begin
                    st_d.phase = PH_DONE;
                end else if (rise_ref_i) begin
                    if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
                    else                     st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phase  <= PH_IDLE;
            st_q.cnt    <= '0;
            st_q.ovf    <= 1'b0;
            st_q.sticky <= 1'b0;
            st_q.hit    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o      = st_q.hit;
    assign hit_seen_o = st_q.sticky;
    assign count_o    = st_q.cnt;
    assign done_o     = (st_q.phase == PH_DONE);
    assign ovf_o      = st_q.ovf;
endmodule

// File: rtl/edge_coincidence_counter.sv
module edge_coincidence_counter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             sig_a_i,
    input  logic             sig_b_i,
    input  logic             qual_a_i,
    input  logic             qual_b_i,
    output logic             hit_o,
    output logic             hit_seen_o,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             ovf_o
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw, synced, rises;

    assign raw = {sig_b_i, sig_a_i};

    ecc_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (synced)
    );

    ecc_rise_det #(.W(NSIG)) i_rise (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cur_i  (synced),
        .rise_o (rises)
    );

    ecc_meas #(.CNT_W(CNT_W)) i_meas (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .rise_ref_i (rises[0]),
        .rise_oth_i (rises[1]),
        .qual_a_i   (qual_a_i),
        .qual_b_i   (qual_b_i),
        .hit_o      (hit_o),
        .hit_seen_o (hit_seen_o),
        .count_o    (count_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o)
    );
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             hit_o,
    input logic             hit_seen_o,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o,
    input logic             ovf_o
);
    assert_hit_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);

    assert_sticky_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_seen_o && !start_i) |=> hit_seen_o);

    assert_start_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (count_o == '0 && !done_o && !ovf_o && !hit_seen_o));

    assert_count_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!start_i && !done_o) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    assert_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> (done_o && $stable(count_o)));

    assert_ovf_saturated_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |-> (count_o == {CNT_W{1'b1}}));

    assert_reset_clears_R10: assert property (@(posedge clk_i)
        rst_i |=> (!hit_o && !hit_seen_o && !done_o && !ovf_o && count_o == '0));
endmodule

bind edge_coincidence_counter ecc_checker #(.CNT_W(CNT_W)) i_ecc_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .hit_o      (hit_o),
    .hit_seen_o (hit_seen_o),
    .count_o    (count_o),
    .done_o     (done_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_edge_coincidence_counter.sv
module test_edge_coincidence_counter;
    localparam int CW = 4;
    localparam logic [CW-1:0] MAXC = {CW{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1, start = 1'b0, a = 1'b0, b = 1'b0, qa = 1'b1, qb = 1'b1;
    logic hit, seen, done, ovf;
    logic [CW-1:0] cnt;

    int checks = 0, errors = 0;
    int cycles = 0;
    bit finished = 0;

    // bench reference model state
    logic m_a1, m_a2, m_a3, m_b1, m_b2, m_b3;
    logic m_hit, m_seen, m_ovf;
    int   m_phase; // 0 idle, 1 counting, 2 done
    logic [CW-1:0] m_cnt;

    always #2.5 clk = ~clk;

    edge_coincidence_counter #(.CNT_W(CW)) i_edge_coincidence_counter (
        .clk_i(clk), .rst_i(rst), .start_i(start), .sig_a_i(a), .sig_b_i(b),
        .qual_a_i(qa), .qual_b_i(qb), .hit_o(hit), .hit_seen_o(seen),
        .count_o(cnt), .done_o(done), .ovf_o(ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic ra, rb, coin;
        if (rst) begin
            {m_a1, m_a2, m_a3, m_b1, m_b2, m_b3} = '0;
            m_hit = 0; m_seen = 0; m_ovf = 0; m_phase = 0; m_cnt = '0;
        end else begin
            ra = m_a2 & ~m_a3;
            rb = m_b2 & ~m_b3;
            coin = ra & rb & qa & qb;
            m_a3 = m_a2; m_a2 = m_a1; m_a1 = a;
            m_b3 = m_b2; m_b2 = m_b1; m_b1 = b;
            m_hit = coin;
            if (start) begin
                m_phase = 1; m_cnt = '0; m_ovf = 0; m_seen = 0;
            end else begin
                if (coin) m_seen = 1;
                if (m_phase == 1) begin
                    if (coin) m_phase = 2;
                    else if (ra) begin
                        if (m_cnt == MAXC) m_ovf = 1;
                        else m_cnt = m_cnt + 1'b1;
                    end
                end
            end
        end
    endtask

    // one sample cycle: edge, model update, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R4 hit pulse", hit, m_hit);
        chk("R5 sticky flag", seen, m_seen);
        chk("R7 count", cnt, m_cnt);
        chk("R8 done", done, m_phase == 2);
        chk("R9 overflow", ovf, m_ovf);
    endtask

    task automatic pulse_a();
        a = 1; tick(); tick(); a = 0; tick(); tick();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        tick(); tick(); tick();
        // R10: reset state
        chk("R10 reset count", cnt, 0);
        chk("R10 reset flags", {hit, seen, done, ovf}, 0);
        rst = 0; tick();

        // R7: no counting before start
        pulse_a();
        chk("R7 idle no count", cnt, 0);

        start = 1; tick(); start = 0;
        chk("R6 start clears", {done, ovf, seen}, 0);
        pulse_a(); pulse_a(); pulse_a();
        chk("R7 three edges", cnt, 3);
        // R2: falling edge and steady high do not count
        a = 1; tick(); tick(); tick();
        chk("R2 rise counted once", cnt, 4);
        a = 0; tick(); tick(); tick(); tick();
        chk("R2 falling edge ignored", cnt, 4);

        // R3: qualifier low blocks coincidence
        qb = 0; a = 1; b = 1; tick(); tick(); tick();
        chk("R3 qualifier gates hit", hit, 0);
        chk("R3 no done", done, 0);
        chk("R3 edge counted", cnt, 5);
        qb = 1; a = 0; b = 0; tick(); tick(); tick();

        // R1: latency of a qualified coincidence
        a = 1; b = 1; tick();
        chk("R1 no hit after edge k", hit, 0);
        tick();
        chk("R1 no hit after edge k+1", hit, 0);
        tick();
        chk("R1 hit after edge k+2", hit, 1);
        chk("R8 done set", done, 1);
        chk("R8 coincident edge not counted", cnt, 5);
        tick();
        chk("R4 pulse one cycle", hit, 0);
        a = 0; b = 0; tick(); tick();
        pulse_a(); pulse_a();
        chk("R8 count frozen", cnt, 5);
        chk("R5 sticky held", seen, 1);

        start = 1; tick(); start = 0;
        chk("R6 restart count", cnt, 0);
        chk("R6 restart flags", {done, seen}, 0);

        // R9: saturation
        for (int i = 0; i < 17; i++) pulse_a();
        chk("R9 saturated", cnt, 15);
        chk("R9 overflow flag", ovf, 1);

        // R11: start on the coincidence cycle
        a = 1; b = 1; tick(); tick(); start = 1; tick(); start = 0;
        chk("R11 hit pulse kept", hit, 1);
        chk("R11 sticky cleared", seen, 0);
        chk("R11 not done", done, 0);
        chk("R11 count restarted", cnt, 0);
        a = 0; b = 0; tick(); tick(); tick();

        // R10: previous samples cleared, held-high inputs seen as rising
        a = 1; b = 1; tick(); tick(); tick();
        rst = 1; tick(); tick(); rst = 0;
        tick(); tick(); tick();
        chk("R10 rise after reset", hit | seen, 1);
        a = 0; b = 0; tick(); tick(); tick();

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 12) begin a = ~a; b = ~b; end
            else if (r < 40) a = ~a;
            else if (r < 60) b = ~b;
            qa = ($urandom_range(0, 99) < 85);
            qb = ($urandom_range(0, 99) < 85);
            start = ($urandom_range(0, 99) < 3);
            rst = ($urandom_range(0, 999) < 4);
            tick();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule